// File: doc/BRIEF.md
# Load Resolve Stage with Store-Queue Snoop

This block is the second stage of a load unit. It receives one scheduled memory transaction per cycle (word address, byte mask, kind, I/O flag, sign flag), the data-cache hit flag and line data, and a flattened snapshot of every store-queue entry: valid bit, word address, byte mask, data, whether it is a store, whether it is a fence/AMO-style blocker, and the entry's own hazard mask. One cycle later it reports one of three outcomes. The load completes with forwarded store data, the load completes with cache data, or the transaction must be written into the store queue together with a hazard vector.

For loads, the newest matching store is the one that no other matching store waits on. A load is forwarded only when that entry is unique and covers every requested byte. Any partial cover, any valid blocker entry, an I/O access or a cache miss sends the load to the queue. Stores and fences always go to the queue. For them, only the hazard vector is computed.

Top module: `ld_resolve`

## Requirements
- R1: A load with `req_io`=1 is queued (action 3) whatever the cache hit and snoop results are. Its hazard vector holds the valid overlapping stores plus the valid blockers.
- R2: If a unique newest overlapping store covers every byte of the load and no blocker is valid, the load completes with action 1 and that store's data.
- R3: Among several overlapping stores, the newest is the one whose index no other overlapping store has set in its hazard mask (`sq_hazard[j*N+i]`=1 means entry j waits on entry i). Forwarding uses the newest, whatever the entry indices.
- R4: If the newest overlapping store does not cover all requested bytes, the load is queued. Its hazard vector holds the overlapping stores.
- R5: Any valid entry with `sq_blocker`=1 queues a load, and that entry's bit is set in the hazard vector.
- R6: With no overlapping store, no blocker and `dc_hit`=1, the load completes with action 2 and cache data. Overlaps with queued loads (`sq_store`=0) and with invalid entries are ignored.
- R7: With no overlapping store and `dc_hit`=0, the load is queued with a zero hazard vector.
- R8: A store (kind 1) is always queued. Its hazard vector holds every valid entry of either kind that overlaps it at the same word address, plus every valid blocker.
- R9: A fence (kind 2) is always queued, and its hazard vector equals the set of valid entries.
- R10: The result appears exactly one cycle after `req_valid`, and `res_valid` is low otherwise. After reset, every output is zero.
- R11: Load data is taken from the lowest set byte of the mask, with a width equal to the number of set bytes (1, 2, 4 or 8). With `req_signed`=1 it is sign-extended, otherwise zero-extended. Byte lane b is bits 8b+7:8b.
- R12: A completed load reports a zero hazard vector. A queued result reports zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transaction present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 fence |
| req_io | input | 1 | I/O access |
| req_signed | input | 1 | Sign-extend load data |
| req_addr | input | WA_W | Word address |
| req_mask | input | BYTES | Byte mask |
| dc_hit | input | 1 | Data cache hit |
| dc_data | input | DATA_W | Data cache word |
| sq_valid | input | N | Entry valid |
| sq_addr | input | N*WA_W | Entry word addresses, entry i at i*WA_W |
| sq_mask | input | N*BYTES | Entry byte masks |
| sq_data | input | N*DATA_W | Entry data |
| sq_store | input | N | Entry is a store |
| sq_blocker | input | N | Entry is a fence/AMO blocker |
| sq_hazard | input | N*N | Entry hazard masks, bit i*N+j |
| res_valid | output | 1 | Result valid |
| res_action | output | 2 | 0 none, 1 forward, 2 cache, 3 queue |
| res_data | output | DATA_W | Aligned, extended load data |
| res_hazard | output | N | Hazard vector for the new queue entry |

## Verification
On every cycle, the assertions check the outcomes that depend only on the request class. I/O loads, stores and fences must be queued, and a valid blocker forbids completion. A fence's hazard equals the valid set, completions carry no hazard, and the result follows the request by one cycle. The choice of the newest store among several matches, partial-cover detection, byte alignment with sign extension, and the exact hazard sets of loads and stores depend on the data. Only the bench's directed scenarios show these.

// File: rtl/ld_resolve_pkg.sv
// Shared encodings for the load resolve stage.
package ld_resolve_pkg;
    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FENCE = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_FWD   = 2'd1,
        ACT_CACHE = 2'd2,
        ACT_QUEUE = 2'd3
    } act_e;
endpackage

// File: rtl/sq_snoop.sv
// Per-entry comparison of a request against every store-queue entry.
// Assumes masks and addresses are packed with entry i at slice i.
module sq_snoop #(
    parameter int N     = 8,
    parameter int WA_W  = 29,
    parameter int BYTES = 8
) (
    input  logic [WA_W-1:0]    req_addr,
    input  logic [BYTES-1:0]   req_mask,
    input  logic [N-1:0]       sq_valid,
    input  logic [N*WA_W-1:0]  sq_addr,
    input  logic [N*BYTES-1:0] sq_mask,
    input  logic [N-1:0]       sq_store,
    input  logic [N-1:0]       sq_blocker,
    output logic [N-1:0]       overlap,
    output logic [N-1:0]       store_hit,
    output logic [N-1:0]       block_vec
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic same_word;
        logic byte_touch;
        // Compare address and byte lanes for one entry.
        always_comb begin
            same_word    = sq_addr[g*WA_W +: WA_W] == req_addr;
            byte_touch   = |(sq_mask[g*BYTES +: BYTES] & req_mask);
            overlap[g]   = sq_valid[g] & same_word & byte_touch;
            store_hit[g] = overlap[g] & sq_store[g];
            block_vec[g] = sq_valid[g] & sq_blocker[g];
        end
    end
endmodule

// File: rtl/newest_pick.sv
// Selects the newest candidate entry: one that no other candidate waits on.
// Assumes hazard bit i*N+j means entry i waits on entry j.
module newest_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]   cand,
    input  logic [N*N-1:0] sq_hazard,
    output logic [N-1:0]   pick,
    output logic           pick_ok
);
    // Mark each candidate that some other candidate depends on.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic waited;
            waited = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && cand[j] && sq_hazard[j*N + i]) waited = 1'b1;
            end
            pick[i] = cand[i] & ~waited;
        end
        pick_ok = $countones(pick) == 1;
    end
endmodule

// File: rtl/load_align.sv
// Extracts load bytes starting at the lowest set mask bit and extends them.
// Assumes a contiguous mask of 1, 2, 4 or 8 bytes.
module load_align #(
    parameter int BYTES = 8,
    localparam int DATA_W = BYTES * 8,
    localparam int OFF_W  = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [BYTES-1:0]  mask,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] aligned
);
    logic [OFF_W-1:0] off;
    logic [OFF_W:0]   cnt;
    logic             found;
    logic             sgn;
    logic [DATA_W-1:0] shifted;

    // Find offset and size, shift down, then fill upper lanes.
    always_comb begin
        off   = '0;
        found = 1'b0;
        cnt   = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (!found && mask[b]) begin
                off   = OFF_W'(b);
                found = 1'b1;
            end
            cnt = cnt + {{OFF_W{1'b0}}, mask[b]};
        end
        shifted = raw >> {off, 3'b000};
        sgn = 1'b0;
        for (int b = 0; b < BYTES; b++) begin
            if (b == int'(cnt) - 1) sgn = shifted[b*8 + 7];
        end
        for (int b = 0; b < BYTES; b++) begin
            aligned[b*8 +: 8] = (b < int'(cnt)) ? shifted[b*8 +: 8] : {8{sign_ext & sgn}};
        end
    end
endmodule

// File: rtl/ld_resolve.sv
// Second-stage resolve for loads, stores and fences against a store-queue snoop.
// Assumes the snoop snapshot is coherent with the request in the same cycle;
// the result is registered and appears one cycle later.
module ld_resolve
    import ld_resolve_pkg::*;
#(
    parameter int N      = 8,
    parameter int WA_W   = 29,
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic                req_io,
    input  logic                req_signed,
    input  logic [WA_W-1:0]     req_addr,
    input  logic [BYTES-1:0]    req_mask,
    input  logic                dc_hit,
    input  logic [DATA_W-1:0]   dc_data,
    input  logic [N-1:0]        sq_valid,
    input  logic [N*WA_W-1:0]   sq_addr,
    input  logic [N*BYTES-1:0]  sq_mask,
    input  logic [N*DATA_W-1:0] sq_data,
    input  logic [N-1:0]        sq_store,
    input  logic [N-1:0]        sq_blocker,
    input  logic [N*N-1:0]      sq_hazard,
    output logic                res_valid,
    output logic [1:0]          res_action,
    output logic [DATA_W-1:0]   res_data,
    output logic [N-1:0]        res_hazard
);
    logic [N-1:0]      overlap, store_hit, block_vec, pick;
    logic              pick_ok;
    logic [BYTES-1:0]  fwd_mask;
    logic [DATA_W-1:0] fwd_data, merged, aligned;
    logic              covered;
    act_e              act_d;
    logic [N-1:0]      haz_d;
    kind_e             kind;

    assign kind = kind_e'(req_kind);

    sq_snoop #(.N(N), .WA_W(WA_W), .BYTES(BYTES)) u_snoop (
        .req_addr  (req_addr),
        .req_mask  (req_mask),
        .sq_valid  (sq_valid),
        .sq_addr   (sq_addr),
        .sq_mask   (sq_mask),
        .sq_store  (sq_store),
        .sq_blocker(sq_blocker),
        .overlap   (overlap),
        .store_hit (store_hit),
        .block_vec (block_vec)
    );

    newest_pick #(.N(N)) u_pick (
        .cand     (store_hit),
        .sq_hazard(sq_hazard),
        .pick     (pick),
        .pick_ok  (pick_ok)
    );

    // Gather mask and data of the picked entry (one-hot OR mux).
    always_comb begin
        fwd_mask = '0;
        fwd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (pick[i]) begin
                fwd_mask = fwd_mask | sq_mask[i*BYTES +: BYTES];
                fwd_data = fwd_data | sq_data[i*DATA_W +: DATA_W];
            end
        end
        covered = pick_ok && ((fwd_mask & req_mask) == req_mask);
    end

    // Per-lane merge: store lanes where the entry writes, cache lanes elsewhere.
    always_comb begin
        for (int b = 0; b < BYTES; b++) begin
            merged[b*8 +: 8] = fwd_mask[b] ? fwd_data[b*8 +: 8] : dc_data[b*8 +: 8];
        end
    end

    load_align #(.BYTES(BYTES)) u_align (
        .raw     (merged),
        .mask    (req_mask),
        .sign_ext(req_signed),
        .aligned (aligned)
    );

    // Choose the outcome and the hazard vector for this request.
    always_comb begin
        act_d = ACT_QUEUE;
        haz_d = '0;
        unique case (kind)
            KIND_LOAD: begin
                if (req_io || (|block_vec)) begin
                    haz_d = store_hit | block_vec;
                end else if (|store_hit) begin
                    if (covered) act_d = ACT_FWD;
                    else         haz_d = store_hit;
                end else if (dc_hit) begin
                    act_d = ACT_CACHE;
                end
            end
            KIND_STORE: haz_d = overlap | block_vec;
            default:    haz_d = sq_valid;
        endcase
    end

    // Register the result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_action <= ACT_NONE;
            res_data   <= '0;
            res_hazard <= '0;
        end else if (req_valid) begin
            res_valid  <= 1'b1;
            res_action <= act_d;
            res_data   <= (act_d == ACT_QUEUE) ? '0 : aligned;
            res_hazard <= haz_d;
        end else begin
            res_valid  <= 1'b0;
            res_action <= ACT_NONE;
            res_data   <= '0;
            res_hazard <= '0;
        end
    end
endmodule

// File: rtl/ld_resolve_chk.sv
// Cycle-by-cycle properties of the resolve stage, bound to the top module.
module ld_resolve_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [1:0]   req_kind,
    input logic         req_io,
    input logic [N-1:0] sq_valid,
    input logic [N-1:0] sq_blocker,
    input logic         res_valid,
    input logic [1:0]   res_action,
    input logic [N-1:0] res_hazard
);
    AST_IO_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd0 && req_io |=> res_action == 2'd3); // R1
    AST_BLOCKER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd0 && |(sq_valid & sq_blocker) |=> res_action == 2'd3); // R5
    AST_STORE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd1 |=> res_action == 2'd3); // R8
    AST_FENCE_ALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd2 |=> res_action == 2'd3 && res_hazard == $past(sq_valid)); // R9
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && res_action == 2'd0); // R10
    AST_DONE_NO_HAZ: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_action != 2'd3 |-> res_hazard == '0); // R12
endmodule

bind ld_resolve ld_resolve_chk #(.N(N)) u_ld_resolve_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_io    (req_io),
    .sq_valid  (sq_valid),
    .sq_blocker(sq_blocker),
    .res_valid (res_valid),
    .res_action(res_action),
    .res_hazard(res_hazard)
);

// File: tb/ld_resolve_bench.sv
// Directed scenarios for the load resolve stage; one task per scenario.
module ld_resolve_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 8;
    localparam int WA_W   = 29;
    localparam int DATA_W = 64;
    localparam int BYTES  = DATA_W / 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [1:0]          req_kind = '0;
    logic                req_io = 1'b0;
    logic                req_signed = 1'b0;
    logic [WA_W-1:0]     req_addr = '0;
    logic [BYTES-1:0]    req_mask = '0;
    logic                dc_hit = 1'b0;
    logic [DATA_W-1:0]   dc_data = '0;
    logic [N-1:0]        sq_valid = '0;
    logic [N*WA_W-1:0]   sq_addr = '0;
    logic [N*BYTES-1:0]  sq_mask = '0;
    logic [N*DATA_W-1:0] sq_data = '0;
    logic [N-1:0]        sq_store = '0;
    logic [N-1:0]        sq_blocker = '0;
    logic [N*N-1:0]      sq_hazard = '0;
    logic                res_valid;
    logic [1:0]          res_action;
    logic [DATA_W-1:0]   res_data;
    logic [N-1:0]        res_hazard;

    int total = 0;
    int bad = 0;

    localparam logic [WA_W-1:0] ADDR_A = 29'h0123_4560;
    localparam logic [WA_W-1:0] ADDR_B = 29'h0000_0777;
    localparam logic [63:0] DC_WORD = 64'h8877_6655_4433_2211;

    always #(CLK_PERIOD/2) clk = ~clk;

    ld_resolve u_ld_resolve (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_io(req_io), .req_signed(req_signed), .req_addr(req_addr),
        .req_mask(req_mask), .dc_hit(dc_hit), .dc_data(dc_data),
        .sq_valid(sq_valid), .sq_addr(sq_addr), .sq_mask(sq_mask),
        .sq_data(sq_data), .sq_store(sq_store), .sq_blocker(sq_blocker),
        .sq_hazard(sq_hazard), .res_valid(res_valid), .res_action(res_action),
        .res_data(res_data), .res_hazard(res_hazard)
    );

    task automatic check_val(input string req, input string what,
                             input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_res(input string req, input logic [1:0] act,
                             input logic [63:0] data, input logic [N-1:0] haz);
        check_val(req, "valid", 64'(res_valid), 64'd1);
        check_val(req, "action", 64'(res_action), 64'(act));
        check_val(req, "data", res_data, data);
        check_val(req, "hazard", 64'(res_hazard), 64'(haz));
    endtask

    task automatic clear_sq();
        sq_valid = '0; sq_addr = '0; sq_mask = '0; sq_data = '0;
        sq_store = '0; sq_blocker = '0; sq_hazard = '0;
    endtask

    task automatic set_ent(input int i, input logic st, input logic blk,
                           input logic [WA_W-1:0] a, input logic [7:0] m,
                           input logic [63:0] d);
        sq_valid[i] = 1'b1;
        sq_store[i] = st;
        sq_blocker[i] = blk;
        sq_addr[i*WA_W +: WA_W] = a;
        sq_mask[i*BYTES +: BYTES] = m;
        sq_data[i*DATA_W +: DATA_W] = d;
    endtask

    // Issue one request at a falling edge; sample the result one cycle later.
    task automatic issue(input logic [1:0] kind, input logic io, input logic sgn,
                         input logic [WA_W-1:0] a, input logic [7:0] m,
                         input logic hit, input logic [63:0] dd);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_io = io; req_signed = sgn;
        req_addr = a; req_mask = m; dc_hit = hit; dc_data = dd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_val("R10", "reset valid", 64'(res_valid), 64'd0);
        check_val("R10", "reset action", 64'(res_action), 64'd0);
        check_val("R10", "reset data", res_data, 64'd0);
        check_val("R10", "reset hazard", 64'(res_hazard), 64'd0);
    endtask

    task automatic t_cache_align();
        clear_sq();
        issue(2'd0, 1'b0, 1'b1, ADDR_A, 8'h0C, 1'b1, DC_WORD);
        check_res("R6 R11 half", 2'd2, 64'h4433, '0);
        issue(2'd0, 1'b0, 1'b1, ADDR_A, 8'h80, 1'b1, DC_WORD);
        check_res("R11 signed byte", 2'd2, 64'hFFFF_FFFF_FFFF_FF88, '0);
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'h80, 1'b1, DC_WORD);
        check_res("R11 unsigned byte", 2'd2, 64'h88, '0);
        issue(2'd0, 1'b0, 1'b1, ADDR_A, 8'hF0, 1'b1, DC_WORD);
        check_res("R11 signed word", 2'd2, 64'hFFFF_FFFF_8877_6655, '0);
        @(negedge clk);
        check_val("R10", "idle valid", 64'(res_valid), 64'd0);
    endtask

    task automatic t_ignored_entries();
        clear_sq();
        set_ent(0, 1'b0, 1'b0, ADDR_A, 8'hFF, 64'hDEAD);
        set_ent(1, 1'b1, 1'b0, ADDR_A, 8'hFF, 64'hBEEF);
        sq_valid[1] = 1'b0;
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'hFF, 1'b1, DC_WORD);
        check_res("R6 ignore load/invalid", 2'd2, DC_WORD, '0);
    endtask

    task automatic t_miss();
        clear_sq();
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'hFF, 1'b0, DC_WORD);
        check_res("R7 R12 miss", 2'd3, 64'd0, '0);
    endtask

    task automatic t_forward();
        clear_sq();
        set_ent(2, 1'b1, 1'b0, ADDR_A, 8'hFF, 64'h1122_3344_5566_7788);
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'h0F, 1'b1, 64'd0);
        check_res("R2 forward", 2'd1, 64'h5566_7788, '0);
    endtask

    task automatic t_newest();
        clear_sq();
        set_ent(1, 1'b1, 1'b0, ADDR_A, 8'hFF, 64'hAAAA_AAAA_AAAA_AAAA);
        set_ent(5, 1'b1, 1'b0, ADDR_A, 8'hFF, 64'h0102_0304_0506_0708);
        sq_hazard[5*N + 1] = 1'b1;
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'hFF, 1'b1, DC_WORD);
        check_res("R3 newest high index", 2'd1, 64'h0102_0304_0506_0708, '0);
        clear_sq();
        set_ent(6, 1'b1, 1'b0, ADDR_A, 8'hFF, 64'h1111_1111_1111_1111);
        set_ent(3, 1'b1, 1'b0, ADDR_A, 8'hFF, 64'h2222_2222_2222_2222);
        sq_hazard[3*N + 6] = 1'b1;
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'hFF, 1'b1, DC_WORD);
        check_res("R3 newest low index", 2'd1, 64'h2222_2222_2222_2222, '0);
    endtask

    task automatic t_partial();
        clear_sq();
        set_ent(0, 1'b1, 1'b0, ADDR_A, 8'h0F, 64'h5555);
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'hFF, 1'b1, DC_WORD);
        check_res("R4 partial", 2'd3, 64'd0, 8'h01);
    endtask

    task automatic t_blocker();
        clear_sq();
        set_ent(4, 1'b0, 1'b1, ADDR_B, 8'h00, 64'd0);
        issue(2'd0, 1'b0, 1'b0, ADDR_A, 8'hFF, 1'b1, DC_WORD);
        check_res("R5 blocker", 2'd3, 64'd0, 8'h10);
    endtask

    task automatic t_io();
        clear_sq();
        set_ent(2, 1'b1, 1'b0, ADDR_A, 8'hFF, 64'h7777);
        issue(2'd0, 1'b1, 1'b0, ADDR_A, 8'hFF, 1'b1, DC_WORD);
        check_res("R1 io", 2'd3, 64'd0, 8'h04);
    endtask

    task automatic t_store();
        clear_sq();
        set_ent(0, 1'b0, 1'b0, ADDR_A, 8'h03, 64'd0);
        set_ent(1, 1'b1, 1'b0, ADDR_A, 8'h0F, 64'd1);
        set_ent(2, 1'b1, 1'b0, ADDR_B, 8'h0F, 64'd2);
        set_ent(3, 1'b1, 1'b0, ADDR_A, 8'hF0, 64'd3);
        issue(2'd1, 1'b0, 1'b0, ADDR_A, 8'h0F, 1'b1, DC_WORD);
        check_res("R8 store", 2'd3, 64'd0, 8'h03);
    endtask

    task automatic t_fence();
        clear_sq();
        set_ent(0, 1'b1, 1'b0, ADDR_A, 8'h01, 64'd0);
        set_ent(2, 1'b0, 1'b0, ADDR_B, 8'h10, 64'd0);
        set_ent(5, 1'b1, 1'b0, ADDR_B, 8'h80, 64'd0);
        issue(2'd2, 1'b0, 1'b0, ADDR_A, 8'h00, 1'b1, DC_WORD);
        check_res("R9 fence", 2'd3, 64'd0, 8'h25);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cache_align();
        t_ignored_entries();
        t_miss();
        t_forward();
        t_newest();
        t_partial();
        t_blocker();
        t_io();
        t_store();
        t_fence();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule